// File: doc/BRIEF.md
# Eight-Lane Oversampled Serial Byte Receiver

This block receives eight independent asynchronous serial lines that share one baud rate. Each frame is one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A shared divider produces a sampling tick at three times the bit rate. Every lane runs its own six-phase one-hot sequence. The phases are held as bit-sliced vectors, one bit per lane, so all eight lanes advance together in a single step of vector logic.

Each lane has one byte register and a bit in each of three status maps: byte ready, bad stop bit and overrun. A lane finds the end of its byte without a bit counter. Its shift register is armed with a single marker bit in the top position. The byte is complete when that marker drops out of the bottom. A per-lane acknowledge input clears the lane's status bits and re-arms its shift register. Only one byte is held per lane, so software must acknowledge each byte before the next one's first data sample.

The serial pins use inverted polarity. A pin at 0 is idle or a stop bit, and a pin at 1 is a start bit. The pins pass through a two-flop synchroniser and are then inverted for processing.

Top module: `oct_uart_rx`

## Requirements
- R1: The sampling tick is asserted for one clock out of every DIV clocks. A bit lasts three ticks (3*DIV clocks). Phases, shift registers and the status bits set by events change only on tick clocks.
- R2: After reset every lane is waiting for a start bit. The ready, bad-stop and overrun maps read 0, and every byte register reads 0x80. At all times each lane is in exactly one of six phases.
- R3: A start needs the synchronised line (after inversion) to read 0 on two ticks in a row. If the second tick reads 1, the lane goes back to waiting. A pulse shorter than one tick therefore produces no byte and sets no status bit.
- R4: After a confirmed start, the lane passes through two idle phases and then samples. Every sample is followed by two idle phases, so data bits are taken on every third tick. The first sampled value lands in bit 0 of the byte.
- R5: Each sample shifts the byte register right and enters the line value at the top bit. The lane ends data reception when a 1 leaves bit 0, which is the arming marker after eight samples. It then samples the stop bit three ticks after the last data sample.
- R6: On the stop-bit tick the lane's ready bit is set and the lane returns to waiting. Lane c's byte is presented on byte_o bits [8c+7:8c].
- R7: If the stop-bit sample reads 0 (pin held at 1), the lane's bad-stop bit is set on the same tick as its ready bit.
- R8: A data sample taken while the lane's ready bit is set sets the lane's overrun bit. The bit stays set until acknowledged.
- R9: A one-clock acknowledge on lane c clears its ready, bad-stop and overrun bits and reloads its byte register with 0x80. If an event sets a status bit on the same clock, the set wins.
- R10: Lanes are independent. Frames on different lanes with different start times and data are received without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_ni | input | NCH | Serial pins, inverted polarity (0 = idle/stop, 1 = start) |
| ack_i | input | NCH | Per-lane acknowledge, one clock per byte |
| byte_o | output | NCH*W | Byte registers, lane c at bits [W*c+W-1:W*c] |
| ready_o | output | NCH | Byte-ready map |
| frame_err_o | output | NCH | Bad-stop-bit map |
| overrun_o | output | NCH | Sticky overrun map |

## Verification
All eight lanes start frames at staggered clock offsets, carrying all-zero, all-one, alternating and mixed bytes, plus one back-to-back pair. Wrong bit order, a misplaced sample point or lanes that disturb one another show up as data mismatches. One lane ends with a low stop bit, which separates a correct bad-stop flag from a clean frame. A pin pulse shorter than a tick tests the start confirmation: a lane that skips it produces an unexpected byte. A second frame on a lane left unacknowledged must raise overrun. The acknowledge that follows must clear all three status bits and re-arm the byte register to 0x80.

// File: rtl/oct_rx_pkg.sv
package oct_rx_pkg;
  // Per-lane phase indices; each phase is one bit-sliced vector
  typedef enum logic [2:0] {
    PH_HUNT,    // idle line, looking for a start bit
    PH_VERIFY,  // start seen once, confirming
    PH_GAP1,    // first tick between samples
    PH_GAP2,    // second tick between samples
    PH_TAKE,    // data sample tick
    PH_STOP     // stop bit sample tick
  } phase_e;

  localparam int unsigned NUM_PHASES = 6;
endpackage

// File: rtl/oct_rx_tick.sv
module oct_rx_tick #(
  parameter int DIV = 174
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/oct_rx_sync.sv
module oct_rx_sync #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pins_i,
  output logic [NCH-1:0] line_o
);
  logic [NCH-1:0] meta_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= pins_i;
      hold_q <= meta_q;
    end
  end

  // pins are inverted: true level 1 = idle/stop, 0 = start
  assign line_o = ~hold_q;
endmodule

// File: rtl/oct_rx_shreg.sv
module oct_rx_shreg #(
  parameter int NCH = 8,
  parameter int W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NCH-1:0]   take_i,
  input  logic [NCH-1:0]   line_i,
  input  logic [NCH-1:0]   ack_i,
  output logic [NCH*W-1:0] bytes_o,
  output logic [NCH-1:0]   spill_o
);
  localparam logic [W-1:0] ARM = {1'b1, {(W-1){1'b0}}};

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic [W-1:0] sr_q, sr_d;
    logic         shift_en;

    assign shift_en = tick_i & take_i[g];
    // bit shifted out of position 0 on a sample tick
    assign spill_o[g] = shift_en & sr_q[0];
    assign bytes_o[g*W +: W] = sr_q;

    always_comb begin
      sr_d = sr_q;
      if (ack_i[g])  sr_d = ARM;
      if (shift_en)  sr_d = {line_i[g], sr_q[W-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= ARM;
      else         sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/oct_rx_slices.sv
module oct_rx_slices
  import oct_rx_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NCH-1:0] line_i,
  input  logic [NCH-1:0] spill_i,
  input  logic [NCH-1:0] ack_i,
  output logic [NCH-1:0] hunt_o,
  output logic [NCH-1:0] verify_o,
  output logic [NCH-1:0] gap1_o,
  output logic [NCH-1:0] gap2_o,
  output logic [NCH-1:0] take_o,
  output logic [NCH-1:0] stop_o,
  output logic [NCH-1:0] ready_o,
  output logic [NCH-1:0] frame_o,
  output logic [NCH-1:0] ovr_o
);
  logic [NCH-1:0] ph_q [NUM_PHASES];
  logic [NCH-1:0] ph_d [NUM_PHASES];
  logic [NCH-1:0] full_q, full_d;
  logic [NCH-1:0] rdy_q, rdy_d;
  logic [NCH-1:0] fe_q, fe_d;
  logic [NCH-1:0] ov_q, ov_d;

  // phase vectors and completion flag, advanced on the tick only
  always_comb begin
    ph_d   = ph_q;
    full_d = full_q;
    if (tick_i) begin
      ph_d[PH_HUNT]   = ((ph_q[PH_HUNT] | ph_q[PH_VERIFY]) & line_i) | ph_q[PH_STOP];
      ph_d[PH_VERIFY] = ph_q[PH_HUNT] & ~line_i;
      ph_d[PH_GAP1]   = (ph_q[PH_VERIFY] & ~line_i) | ph_q[PH_TAKE];
      ph_d[PH_GAP2]   = ph_q[PH_GAP1];
      ph_d[PH_TAKE]   = ph_q[PH_GAP2] & ~full_q;
      ph_d[PH_STOP]   = ph_q[PH_GAP2] & full_q;
      full_d          = (full_q | spill_i) & ~ph_q[PH_GAP2];
    end
  end

  // status maps: acknowledge clears on any clock, tick events set and win
  always_comb begin
    rdy_d = rdy_q & ~ack_i;
    fe_d  = fe_q  & ~ack_i;
    ov_d  = ov_q  & ~ack_i;
    if (tick_i) begin
      rdy_d = rdy_d | ph_q[PH_STOP];
      fe_d  = fe_d  | (ph_q[PH_STOP] & ~line_i);
      ov_d  = ov_d  | (ph_q[PH_TAKE] & rdy_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PHASES; p++) begin
        ph_q[p] <= (p == int'(PH_HUNT)) ? '1 : '0;
      end
      full_q <= '0;
      rdy_q  <= '0;
      fe_q   <= '0;
      ov_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      full_q <= full_d;
      rdy_q  <= rdy_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
    end
  end

  assign hunt_o   = ph_q[PH_HUNT];
  assign verify_o = ph_q[PH_VERIFY];
  assign gap1_o   = ph_q[PH_GAP1];
  assign gap2_o   = ph_q[PH_GAP2];
  assign take_o   = ph_q[PH_TAKE];
  assign stop_o   = ph_q[PH_STOP];
  assign ready_o  = rdy_q;
  assign frame_o  = fe_q;
  assign ovr_o    = ov_q;
endmodule

// File: rtl/oct_uart_rx.sv
module oct_uart_rx #(
  parameter int NCH = 8,
  parameter int W   = 8,
  parameter int DIV = 174
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   line_ni,
  input  logic [NCH-1:0]   ack_i,
  output logic [NCH*W-1:0] byte_o,
  output logic [NCH-1:0]   ready_o,
  output logic [NCH-1:0]   frame_err_o,
  output logic [NCH-1:0]   overrun_o
);
  logic rst_meta, rst_q;
  logic tick;
  logic [NCH-1:0] line_t, spill, take;
  logic [NCH-1:0] hunt, verify, gap1, gap2, stop;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  oct_rx_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .tick_o(tick)
  );

  oct_rx_sync #(.NCH(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .pins_i(line_ni),
    .line_o(line_t)
  );

  oct_rx_slices #(.NCH(NCH)) u_slices (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .tick_i  (tick),
    .line_i  (line_t),
    .spill_i (spill),
    .ack_i   (ack_i),
    .hunt_o  (hunt),
    .verify_o(verify),
    .gap1_o  (gap1),
    .gap2_o  (gap2),
    .take_o  (take),
    .stop_o  (stop),
    .ready_o (ready_o),
    .frame_o (frame_err_o),
    .ovr_o   (overrun_o)
  );

  oct_rx_shreg #(.NCH(NCH), .W(W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .tick_i (tick),
    .take_i (take),
    .line_i (line_t),
    .ack_i  (ack_i),
    .bytes_o(byte_o),
    .spill_o(spill)
  );
endmodule

// File: rtl/oct_rx_check.sv
module oct_rx_check #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           tick,
  input logic [NCH-1:0] line,
  input logic [NCH-1:0] ack,
  input logic [NCH-1:0] hunt,
  input logic [NCH-1:0] verify,
  input logic [NCH-1:0] gap1,
  input logic [NCH-1:0] gap2,
  input logic [NCH-1:0] take,
  input logic [NCH-1:0] stop,
  input logic [NCH-1:0] ready,
  input logic [NCH-1:0] frame,
  input logic [NCH-1:0] ovr
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_one_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
      $countones({hunt[c], verify[c], gap1[c], gap2[c], take[c], stop[c]}) == 1);

    assert_phase_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
      !tick |=> $stable(hunt[c]) && $stable(take[c]) && $stable(stop[c]));

    assert_glitch_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && verify[c] && line[c] |=> hunt[c]);

    assert_take_to_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && take[c] |=> gap1[c]);

    assert_gap_chain_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && gap1[c] |=> gap2[c]);

    assert_stop_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && stop[c] |=> ready[c] && hunt[c]);

    assert_bad_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && stop[c] && !line[c] |=> frame[c]);

    assert_overrun_set_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick && take[c] && ready[c] |=> ovr[c]);

    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      ack[c] && !(tick && stop[c]) |=> !ready[c]);

    assert_ready_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      !tick && !ack[c] |=> $stable(ready[c]) && $stable(frame[c]) && $stable(ovr[c]));
  end
endmodule

bind oct_uart_rx oct_rx_check #(.NCH(NCH)) u_check (
  .clk_i (clk_i),
  .rst_n (rst_q),
  .tick  (tick),
  .line  (line_t),
  .ack   (ack_i),
  .hunt  (hunt),
  .verify(verify),
  .gap1  (gap1),
  .gap2  (gap2),
  .take  (take),
  .stop  (stop),
  .ready (ready_o),
  .frame (frame_err_o),
  .ovr   (overrun_o)
);

// File: tb/test_oct_uart_rx.sv
module test_oct_uart_rx;
  localparam int NCH  = 8;
  localparam int W    = 8;
  localparam int DIV  = 6;
  localparam int BITC = 3 * DIV;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]   line_pins;
  logic [NCH-1:0]   mon_ack;
  logic [NCH-1:0]   man_ack;
  logic [NCH-1:0]   ack_all;
  logic [NCH*W-1:0] byte_o;
  logic [NCH-1:0]   ready_o, frame_err_o, overrun_o;

  assign ack_all = mon_ack | man_ack;

  always #2.5 clk = ~clk;

  oct_uart_rx #(.NCH(NCH), .W(W), .DIV(DIV)) i_oct_uart_rx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_ni    (line_pins),
    .ack_i      (ack_all),
    .byte_o     (byte_o),
    .ready_o    (ready_o),
    .frame_err_o(frame_err_o),
    .overrun_o  (overrun_o)
  );

  int nchecks = 0;
  int nfail   = 0;
  logic [8:0]     exp_q [NCH][$];
  logic [NCH-1:0] auto_ack;
  logic [NCH-1:0] prev_rdy;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // driver: records the expected item, then drives one frame on pin c
  task automatic send_frame(input int c, input logic [7:0] b, input bit good_stop);
    exp_q[c].push_back({~good_stop, b});
    line_pins[c] = 1'b1;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line_pins[c] = ~b[i];
      repeat (BITC) @(negedge clk);
    end
    line_pins[c] = good_stop ? 1'b0 : 1'b1;
    repeat (BITC) @(negedge clk);
    line_pins[c] = 1'b0;
  endtask

  function automatic logic [7:0] lane_byte(input int c);
    case (c)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h55;
      3: return 8'hA3;
      4: return 8'h81;
      5: return 8'h7E;
      6: return 8'h12;
      default: return 8'hC9;
    endcase
  endfunction

  task automatic run_lane(input int c);
    repeat (c * 7 + 1) @(negedge clk);
    send_frame(c, lane_byte(c), c != 3);
    if (c == 0) send_frame(0, 8'h6B, 1'b1);  // back to back
  endtask

  // monitor: pops the expected item on each rising ready bit
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_ack  = '0;
      prev_rdy = '0;
    end else begin
      mon_ack = '0;
      for (int c = 0; c < NCH; c++) begin
        if (ready_o[c] && !prev_rdy[c]) begin
          if (exp_q[c].size() == 0) begin
            check(1'b0, $sformatf("R3 R10 unexpected byte lane %0d", c), byte_o[c*W +: W], 0);
          end else begin
            logic [8:0] e;
            e = exp_q[c].pop_front();
            check(byte_o[c*W +: W] == e[7:0],
                  $sformatf("R1 R4 R5 R6 data lane %0d", c), byte_o[c*W +: W], e[7:0]);
            check(frame_err_o[c] == e[8],
                  $sformatf("R7 bad stop flag lane %0d", c), frame_err_o[c], e[8]);
            check(overrun_o[c] == 1'b0,
                  $sformatf("R8 no overrun on first byte lane %0d", c), overrun_o[c], 0);
            if (auto_ack[c]) mon_ack[c] = 1'b1;
          end
        end
      end
      prev_rdy = ready_o;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    line_pins = '0;
    man_ack   = '0;
    auto_ack  = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(ready_o == '0, "R2 ready after reset", ready_o, 0);
    check(frame_err_o == '0, "R2 bad stop after reset", frame_err_o, 0);
    check(overrun_o == '0, "R2 overrun after reset", overrun_o, 0);
    for (int c = 0; c < NCH; c++)
      check(byte_o[c*W +: W] == 8'h80, "R2 armed byte after reset", byte_o[c*W +: W], 8'h80);

    // all lanes at once, staggered
    for (int c = 0; c < NCH; c++) begin
      automatic int cc = c;
      fork
        run_lane(cc);
      join_none
    end
    wait fork;
    repeat (10 * BITC) @(negedge clk);
    check(frame_err_o == '0, "R9 bad stop cleared by ack", frame_err_o, 0);
    check(ready_o == '0, "R9 ready cleared by ack", ready_o, 0);
    check(byte_o[3*W +: W] == 8'h80, "R9 byte re-armed by ack", byte_o[3*W +: W], 8'h80);

    // short pulse on lane 5: no start
    line_pins[5] = 1'b1;
    repeat (DIV - 2) @(negedge clk);
    line_pins[5] = 1'b0;
    repeat (12 * BITC) @(negedge clk);
    check(ready_o[5] == 1'b0, "R3 glitch gives no byte", ready_o[5], 0);
    check(frame_err_o[5] == 1'b0, "R3 glitch sets no bad stop", frame_err_o[5], 0);
    check(byte_o[5*W +: W] == 8'h80, "R3 glitch leaves byte armed", byte_o[5*W +: W], 8'h80);
    send_frame(5, 8'h3D, 1'b1);
    repeat (4 * BITC) @(negedge clk);

    // overrun on lane 6
    auto_ack[6] = 1'b0;
    send_frame(6, 8'h3C, 1'b1);
    repeat (4 * BITC) @(negedge clk);
    check(ready_o[6] == 1'b1, "R6 ready held without ack", ready_o[6], 1);
    check(overrun_o[6] == 1'b0, "R8 no overrun yet", overrun_o[6], 0);
    fork
      begin
        line_pins[6] = 1'b1;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          line_pins[6] = ~(8'h5A >> i) & 1'b1;
          repeat (BITC) @(negedge clk);
        end
        line_pins[6] = 1'b0;
      end
    join
    repeat (60 * BITC) @(negedge clk);
    check(overrun_o[6] == 1'b1, "R8 overrun set", overrun_o[6], 1);
    check(ready_o[6] == 1'b1, "R8 ready still set", ready_o[6], 1);
    check(ready_o[5:0] == '0 && ready_o[7] == 1'b0, "R10 other lanes quiet", ready_o, 8'h40);
    man_ack[6] = 1'b1;
    @(negedge clk);
    man_ack[6] = 1'b0;
    check(ready_o[6] == 1'b0, "R9 ack clears ready", ready_o[6], 0);
    check(overrun_o[6] == 1'b0, "R9 ack clears overrun", overrun_o[6], 0);
    check(frame_err_o[6] == 1'b0, "R9 ack clears bad stop", frame_err_o[6], 0);
    check(byte_o[6*W +: W] == 8'h80, "R9 ack re-arms byte", byte_o[6*W +: W], 8'h80);
    @(negedge clk);
    auto_ack[6] = 1'b1;
    send_frame(6, 8'hA5, 1'b1);
    repeat (4 * BITC) @(negedge clk);

    for (int c = 0; c < NCH; c++)
      check(exp_q[c].size() == 0, $sformatf("R6 R10 missing byte lane %0d", c), exp_q[c].size(), 0);

    summary();
    $finish;
  end
endmodule